// File: doc/BRIEF.md
# SPI Command Slave with Response Queue

This block is an SPI slave (mode 0: data sampled on the rising SCK edge, shifted on the falling edge) that lives inside a larger chip and answers a host controller. SCK, chip select and MOSI are brought into the system clock domain through two-flop synchronizers. Every chip-select frame opens with a command byte. The byte the block shifts back in the second slot of any frame is a status byte, so any frame can serve as a poll. From the third slot onward the block returns the data of the oldest pending response.

Responses come from two sources. The first is echo frames, whose payload is stored and returned in later frames. The second is a parallel mailbox toward an internal processor: the block hands over a sub-command and a 24-bit argument, and the processor later posts a 32-bit reply. Responses sit in a small first-in first-out queue. Reading a response never removes it. Only an explicit acknowledge command does that.

Top module: `spi_cmd_slave`

## Requirements
- R1: The command byte is decoded as follows: 0x10 mailbox message, 0xF1 echo, 0xFD interrupt acknowledge, 0xFE response acknowledge. Every other value, including 0x00 and 0xFF, has no effect on the queue, the mailbox or `irq_ack_o`.
- R2: The byte returned on MISO during the command slot is 0x00, and MISO is low while no frame is open.
- R3: The byte returned during the second slot of every frame is the status byte. Bit 7 is set when at least one response is pending. Bit 6 is the overflow flag. Bits 5..0 are zero.
- R4: From the third slot on, byte k (counting from 0) returns byte k-2 of the oldest pending response. Slots past its length, or any slot when nothing is pending, return 0x00.
- R5: When an echo frame ends, its payload bytes (the bytes after the command, at most MAX_LEN of them) are queued as one new response of that length. Further bytes are ignored.
- R6: Up to NUM_SLOTS responses can be pending. They are returned in first-in, first-out order.
- R7: Reading a response does not remove it. A 0xFE command removes the oldest pending response as soon as the command byte completes, so a one-byte frame is enough and the status byte of the same frame already reflects the removal. 0xFE with nothing pending has no effect.
- R8: An echo frame returns the oldest pending response on MISO while its own payload is being captured (full duplex).
- R9: A 0x10 frame with at least five bytes raises `mbx_valid_o` for exactly one cycle after its fifth byte. `mbx_cmd_o` then holds byte 1, and `mbx_param_o` holds bytes 2..4 with byte 2 as the most significant. A shorter frame issues nothing.
- R10: A mailbox reply strobed on `mbx_rsp_valid_i` is held and then queued as a 4-byte response, most significant byte first, once no frame is open. A reply that arrives while another reply is still held is ignored.
- R11: If an echo command arrives, or a held reply is ready to be queued, while NUM_SLOTS responses are pending, the new response is dropped and the overflow flag (status bit 6) is set. The flag stays set until reset.
- R12: An echo frame that ends early queues the bytes received so far. An echo frame with no payload queues nothing.
- R13: A 0xFD command pulses `irq_ack_o` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI clock from the host |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| irq_ack_o | output | 1 | One-cycle interrupt acknowledge strobe |
| mbx_valid_o | output | 1 | One-cycle strobe: mailbox message ready |
| mbx_cmd_o | output | 8 | Mailbox sub-command |
| mbx_param_o | output | 24 | Mailbox argument |
| mbx_rsp_valid_i | input | 1 | Processor reply strobe |
| mbx_rsp_data_i | input | 32 | Processor reply word |

## Verification
The bench builds the block with NUM_SLOTS = 2 and MAX_LEN = 16. Short frames can therefore fill the queue and reach the overflow path. A 20-byte echo payload crosses the length cap, which exercises the truncation rule without frames hundreds of bytes long. With only two slots, the first-in first-out order, the full-duplex echo of a pending response and the drop of a reply or echo on a full queue all come within a few dozen frames. Every MISO byte is checked against a behavioural queue model.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] CMD_NOP_LO  = 8'h00;
  localparam logic [7:0] CMD_MSG     = 8'h10;
  localparam logic [7:0] CMD_ECHO    = 8'hF1;
  localparam logic [7:0] CMD_IRQ_ACK = 8'hFD;
  localparam logic [7:0] CMD_RSP_ACK = 8'hFE;
  localparam logic [7:0] CMD_NOP_HI  = 8'hFF;
  localparam int         RSP_WORD_B  = 4;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST_VAL[g]}};
      else         ff <= {ff[0], d_i[g]};
    end
    assign q_o[g] = ff[1];
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  input  logic [7:0]       tx_byte_i,
  output logic             frame_start_o,
  output logic             frame_end_o,
  output logic             frame_act_o,
  output logic             byte_done_o,
  output logic [7:0]       rx_byte_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic [CNT_W-1:0] next_idx_o,
  output logic             miso_o
);
  logic             sck_q, csn_q;
  logic [2:0]       bit_cnt;
  logic [7:0]       rx_sr, tx_sr;
  logic [CNT_W-1:0] byte_cnt;
  logic             rise, fall;

  assign frame_start_o = !csn_i && csn_q;
  assign frame_end_o   = frame_act_o && csn_i && !csn_q;
  assign rise          = frame_act_o && sck_i && !sck_q;
  assign fall          = frame_act_o && !sck_i && sck_q;
  assign next_idx_o    = byte_cnt;
  assign miso_o        = tx_sr[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b0;
      csn_q       <= 1'b1;
      frame_act_o <= 1'b0;
      bit_cnt     <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      byte_cnt    <= '0;
      byte_done_o <= 1'b0;
      rx_byte_o   <= '0;
      byte_idx_o  <= '0;
    end else begin
      sck_q       <= sck_i;
      csn_q       <= csn_i;
      byte_done_o <= 1'b0;
      if (frame_start_o) begin
        frame_act_o <= 1'b1;
        bit_cnt     <= '0;
        byte_cnt    <= '0;
        tx_sr       <= '0;
      end else if (frame_end_o) begin
        frame_act_o <= 1'b0;
        tx_sr       <= '0;
      end else begin
        if (rise) begin
          rx_sr   <= {rx_sr[6:0], mosi_i};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done_o <= 1'b1;
            rx_byte_o   <= {rx_sr[6:0], mosi_i};
            byte_idx_o  <= byte_cnt;
            if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
          end
        end
        if (fall) begin
          // next byte is loaded on the first falling edge after a byte boundary
          if (bit_cnt == 3'd0) tx_sr <= tx_byte_i;
          else                 tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_rsp_queue.sv
module spi_cmd_rsp_queue #(
  parameter int NUM_SLOTS = 2,
  parameter int MAX_LEN   = 256,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int OFF_W    = $clog2(MAX_LEN),
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int IDX_W    = LEN_W + 1,
  localparam int QCNT_W   = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [7:0]        wr_data_i,
  input  logic              push_i,
  input  logic [LEN_W-1:0]  push_len_i,
  input  logic              pop_i,
  input  logic [IDX_W-1:0]  rd_off_i,
  output logic [7:0]        rd_data_o,
  output logic [QCNT_W-1:0] count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [7:0]       mem  [NUM_SLOTS][MAX_LEN];
  logic [LEN_W-1:0] lens [NUM_SLOTS];
  logic [SLOT_W-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign full_o  = count_o == QCNT_W'(NUM_SLOTS);
  assign empty_o = count_o == '0;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wptr][wr_off_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr    <= '0;
      rptr    <= '0;
      count_o <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) lens[i] <= '0;
    end else begin
      if (do_push) begin
        lens[wptr] <= push_len_i;
        wptr       <= bump(wptr);
      end
      if (do_pop) rptr <= bump(rptr);
      if (do_push && !do_pop)      count_o <= count_o + 1'b1;
      else if (do_pop && !do_push) count_o <= count_o - 1'b1;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (!empty_o && rd_off_i < IDX_W'(lens[rptr]))
      rd_data_o = mem[rptr][rd_off_i[OFF_W-1:0]];
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int MAX_LEN   = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        csn_i,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        irq_ack_o,
  output logic        mbx_valid_o,
  output logic [7:0]  mbx_cmd_o,
  output logic [23:0] mbx_param_o,
  input  logic        mbx_rsp_valid_i,
  input  logic [31:0] mbx_rsp_data_i
);
  localparam int LEN_W  = $clog2(MAX_LEN + 1);
  localparam int OFF_W  = $clog2(MAX_LEN);
  localparam int IDX_W  = LEN_W + 1;
  localparam int QCNT_W = $clog2(NUM_SLOTS + 1);

  logic sck_s, csn_s, mosi_s;
  spi_cmd_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .d_i({sck_i, csn_i, mosi_i}),
    .q_o({sck_s, csn_s, mosi_s})
  );

  logic             frame_start, frame_end, frame_act, byte_done;
  logic [7:0]       rx_byte, tx_byte;
  logic [IDX_W-1:0] byte_idx, next_idx;

  spi_cmd_shifter #(.CNT_W(IDX_W)) u_shift (
    .clk_i, .rst_ni,
    .sck_i(sck_s), .csn_i(csn_s), .mosi_i(mosi_s),
    .tx_byte_i(tx_byte),
    .frame_start_o(frame_start), .frame_end_o(frame_end), .frame_act_o(frame_act),
    .byte_done_o(byte_done), .rx_byte_o(rx_byte),
    .byte_idx_o(byte_idx), .next_idx_o(next_idx),
    .miso_o
  );

  logic              q_wr_en, q_push, q_pop, q_full, q_empty;
  logic [OFF_W-1:0]  q_wr_off;
  logic [7:0]        q_wr_data, q_rd_data;
  logic [LEN_W-1:0]  q_push_len;
  logic [IDX_W-1:0]  q_rd_off;
  logic [QCNT_W-1:0] q_count;

  spi_cmd_rsp_queue #(.NUM_SLOTS(NUM_SLOTS), .MAX_LEN(MAX_LEN)) u_queue (
    .clk_i, .rst_ni,
    .wr_en_i(q_wr_en), .wr_off_i(q_wr_off), .wr_data_i(q_wr_data),
    .push_i(q_push), .push_len_i(q_push_len), .pop_i(q_pop),
    .rd_off_i(q_rd_off), .rd_data_o(q_rd_data),
    .count_o(q_count), .full_o(q_full), .empty_o(q_empty)
  );

  logic [7:0]       cmd_q;
  logic             echo_ok;
  logic [LEN_W-1:0] echo_len;
  logic             ovf_q;
  logic             hold_valid, drain_act;
  logic [31:0]      hold_data;
  logic [1:0]       drain_cnt;
  logic             is_cmd, echo_wr, echo_push, drain_push;

  assign is_cmd     = byte_done && byte_idx == '0;
  assign echo_wr    = byte_done && byte_idx != '0 && cmd_q == CMD_ECHO && echo_ok
                      && byte_idx <= IDX_W'(MAX_LEN);
  assign echo_push  = frame_end && echo_ok && echo_len != '0;
  assign drain_push = drain_act && drain_cnt == 2'(RSP_WORD_B - 1);

  assign q_pop      = is_cmd && rx_byte == CMD_RSP_ACK;
  assign q_push     = echo_push || drain_push;
  assign q_push_len = drain_act ? LEN_W'(RSP_WORD_B) : echo_len;
  assign q_wr_en    = echo_wr || drain_act;
  assign q_wr_off   = drain_act ? OFF_W'(drain_cnt) : OFF_W'(byte_idx - 1'b1);
  assign q_wr_data  = drain_act ? hold_data[31:24] : rx_byte;
  assign q_rd_off   = next_idx - IDX_W'(2);

  always_comb begin
    if (next_idx == '0)            tx_byte = 8'h00;
    else if (next_idx == IDX_W'(1)) tx_byte = {!q_empty, ovf_q, 6'b0};
    else                           tx_byte = q_rd_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= CMD_NOP_LO;
      echo_ok     <= 1'b0;
      echo_len    <= '0;
      ovf_q       <= 1'b0;
      irq_ack_o   <= 1'b0;
      mbx_valid_o <= 1'b0;
      mbx_cmd_o   <= '0;
      mbx_param_o <= '0;
      hold_valid  <= 1'b0;
      hold_data   <= '0;
      drain_act   <= 1'b0;
      drain_cnt   <= '0;
    end else begin
      irq_ack_o   <= 1'b0;
      mbx_valid_o <= 1'b0;
      if (frame_start) begin
        cmd_q    <= CMD_NOP_LO;
        echo_ok  <= 1'b0;
        echo_len <= '0;
      end
      if (is_cmd) begin
        cmd_q <= rx_byte;
        if (rx_byte == CMD_IRQ_ACK) irq_ack_o <= 1'b1;
        if (rx_byte == CMD_ECHO) begin
          if (q_full) ovf_q   <= 1'b1;
          else        echo_ok <= 1'b1;
        end
      end
      if (echo_wr) echo_len <= LEN_W'(byte_idx);
      if (frame_end) echo_ok <= 1'b0;
      if (byte_done && cmd_q == CMD_MSG) begin
        if (byte_idx == IDX_W'(1)) mbx_cmd_o <= rx_byte;
        else if (byte_idx >= IDX_W'(2) && byte_idx <= IDX_W'(4)) begin
          mbx_param_o <= {mbx_param_o[15:0], rx_byte};
          if (byte_idx == IDX_W'(4)) mbx_valid_o <= 1'b1;
        end
      end
      // held reply is written into the tail slot only between frames
      if (drain_act) begin
        hold_data <= {hold_data[23:0], 8'h00};
        drain_cnt <= drain_cnt + 2'd1;
        if (drain_push) begin
          drain_act  <= 1'b0;
          hold_valid <= 1'b0;
        end
      end else if (hold_valid && !frame_act) begin
        if (q_full) begin
          ovf_q      <= 1'b1;
          hold_valid <= 1'b0;
        end else begin
          drain_act <= 1'b1;
          drain_cnt <= '0;
        end
      end
      if (mbx_rsp_valid_i && !hold_valid) begin
        hold_valid <= 1'b1;
        hold_data  <= mbx_rsp_data_i;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int NUM_SLOTS = 2,
  parameter int QCNT_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miso_o,
  input logic              frame_act,
  input logic              irq_ack_o,
  input logic              mbx_valid_o,
  input logic [QCNT_W-1:0] q_count,
  input logic              q_full,
  input logic              q_empty,
  input logic              q_push,
  input logic              q_pop,
  input logic              ovf_q
);
  AST_MISO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_act |-> !miso_o); // R2
  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= QCNT_W'(NUM_SLOTS)); // R6
  AST_POP_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop && !q_empty && !q_push |=> q_count == $past(q_count) - 1'b1); // R7
  AST_MBX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbx_valid_o |=> !mbx_valid_o); // R9
  AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_push |-> !q_full); // R11
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R11
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o); // R13
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.NUM_SLOTS(NUM_SLOTS), .QCNT_W(QCNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .miso_o(miso_o), .frame_act(frame_act),
  .irq_ack_o(irq_ack_o), .mbx_valid_o(mbx_valid_o), .q_count(q_count),
  .q_full(q_full), .q_empty(q_empty), .q_push(q_push), .q_pop(q_pop), .ovf_q(ovf_q)
);

// File: tb/spi_cmd_slave_bench.sv
module spi_cmd_slave_bench;
  localparam int SLOTS = 2;
  localparam int MAXL  = 16;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, irq_ack, mbx_valid, rsp_valid = 1'b0;
  logic [7:0]  mbx_cmd;
  logic [23:0] mbx_param;
  logic [31:0] rsp_data = '0;

  always #4 clk = ~clk;

  spi_cmd_slave #(.NUM_SLOTS(SLOTS), .MAX_LEN(MAXL)) u_spi_cmd_slave (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .irq_ack_o(irq_ack), .mbx_valid_o(mbx_valid),
    .mbx_cmd_o(mbx_cmd), .mbx_param_o(mbx_param),
    .mbx_rsp_valid_i(rsp_valid), .mbx_rsp_data_i(rsp_data)
  );

  int n_chk = 0, n_fail = 0;
  int mbx_cnt = 0, irq_cnt = 0;
  logic [7:0]  cap_cmd = '0;
  logic [23:0] cap_param = '0;
  logic [7:0] tx_buf [64];
  logic [7:0] rx_buf [64];
  logic [7:0] exp_buf [64];
  logic [7:0] m_data [$];
  int         m_len [$];
  logic       m_ovf = 1'b0;

  always @(posedge clk) begin
    if (mbx_valid) begin mbx_cnt++; cap_cmd <= mbx_cmd; cap_param <= mbx_param; end
    if (irq_ack) irq_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lfsr(input logic [7:0] x);
    return {x[6:0], 1'b0} ^ (x[7] ? 8'h1d : 8'h00);
  endfunction

  task automatic fill(input logic [7:0] cmd, input int n, input logic [7:0] seed);
    logic [7:0] v;
    v = seed;
    tx_buf[0] = cmd;
    for (int i = 1; i < n; i++) begin tx_buf[i] = v; v = lfsr(v); end
  endtask

  task automatic frame(input int n, input string tag);
    logic [7:0] cmd;
    logic take;
    int L;
    string btag;
    cmd = tx_buf[0];
    take = 1'b0;
    if (cmd == 8'hFE && m_len.size() > 0) begin
      for (int i = 0; i < m_len[0]; i++) void'(m_data.pop_front());
      void'(m_len.pop_front());
    end
    if (cmd == 8'hF1) begin
      if (m_len.size() >= SLOTS) m_ovf = 1'b1;
      else take = 1'b1;
    end
    exp_buf[0] = 8'h00;
    exp_buf[1] = {m_len.size() > 0, m_ovf, 6'b0};
    for (int k = 2; k < n; k++)
      exp_buf[k] = (m_len.size() > 0 && k - 2 < m_len[0]) ? m_data[k-2] : 8'h00;
    @(negedge clk) csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = tx_buf[b][i];
        repeat (HALF) @(negedge clk);
        rx_buf[b][i] = miso;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      btag = (b == 0) ? "R2 cmd slot" : (b == 1) ? "R3 status" : "R4 payload";
      chk($sformatf("%s/%s byte %0d", tag, btag, b), rx_buf[b], exp_buf[b]);
    end
    if (take && n > 1) begin
      L = (n - 1 > MAXL) ? MAXL : n - 1;
      for (int i = 0; i < L; i++) m_data.push_back(tx_buf[1+i]);
      m_len.push_back(L);
    end
  endtask

  task automatic reply(input logic [31:0] d);
    @(negedge clk) begin rsp_valid = 1'b1; rsp_data = d; end
    @(negedge clk) rsp_valid = 1'b0;
    repeat (20) @(negedge clk);
    if (m_len.size() >= SLOTS) m_ovf = 1'b1;
    else begin
      for (int i = 3; i >= 0; i--) m_data.push_back(d[8*i +: 8]);
      m_len.push_back(4);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int m0, i0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 reset miso", miso, 0);
    chk("R9 reset mbx_valid", mbx_valid, 0);
    chk("R13 reset irq_ack", irq_ack, 0);

    fill(8'h00, 4, 8'h11); frame(4, "R1 nop low");
    fill(8'h42, 4, 8'h22); frame(4, "R1 unknown cmd");
    fill(8'hF1, 6, 8'h01); frame(6, "R5 echo5");
    fill(8'hFF, 9, 8'h00); frame(9, "R5 poll");
    fill(8'hFF, 9, 8'h00); frame(9, "R7 poll again");
    fill(8'hF1, 21, 8'h37); frame(21, "R8 full duplex");
    fill(8'hF1, 4, 8'h55); frame(4, "R11 echo while full");
    fill(8'hFE, 1, 8'h00); frame(1, "R7 one-byte ack");
    fill(8'h00, 20, 8'h00); frame(20, "R6 fifo second");

    m0 = mbx_cnt;
    tx_buf[0] = 8'h10; tx_buf[1] = 8'h5A; tx_buf[2] = 8'h12; tx_buf[3] = 8'h34; tx_buf[4] = 8'h56;
    frame(5, "R9 msg");
    chk("R9 msg strobe count", mbx_cnt, m0 + 1);
    chk("R9 msg sub-command", cap_cmd, 8'h5A);
    chk("R9 msg param", cap_param, 24'h123456);
    m0 = mbx_cnt;
    frame(4, "R9 short msg");
    chk("R9 short msg no strobe", mbx_cnt, m0);

    reply(32'hCAFEBABE);
    fill(8'hFE, 1, 8'h00); frame(1, "R7 ack");
    fill(8'hFF, 8, 8'h00); frame(8, "R10 reply bytes");
    reply(32'h0BADF00D);
    fill(8'hFF, 4, 8'h00); frame(4, "R6 two pending");
    reply(32'h12345678);
    fill(8'hFF, 8, 8'h00); frame(8, "R11 reply dropped");

    i0 = irq_cnt;
    fill(8'hFD, 2, 8'h00); frame(2, "R13 irq ack");
    chk("R13 irq strobe count", irq_cnt, i0 + 1);
    i0 = irq_cnt;
    fill(8'hFE, 6, 8'h00); frame(6, "R7 long ack");
    chk("R1 ack gives no irq", irq_cnt, i0);
    fill(8'hFE, 6, 8'h00); frame(6, "R7 ack drains");
    fill(8'hFE, 3, 8'h00); frame(3, "R7 ack when empty");

    fill(8'hF1, 4, 8'hA5); frame(4, "R12 partial echo");
    fill(8'hF1, 1, 8'h00); frame(1, "R12 empty echo");
    fill(8'hFF, 7, 8'h00); frame(7, "R12 partial poll");
    fill(8'hFE, 1, 8'h00); frame(1, "R12 ack");
    fill(8'hFF, 3, 8'h00); frame(3, "R12 nothing left");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule